// File: doc/BRIEF.md
# SATA Host DMA Command Sequencer

This block runs one ATA DMA read or DMA write command on the host side of a serial ATA transport layer. Software hands it a command (opcode, 48-bit block address, sector count, direction) while it is idle. The block then builds and sends the host-to-device register frame, and follows the frames the device sends back until the device reports completion. Outbound and inbound frames are 32-bit dword streams that carry start-of-frame and end-of-frame markers. They go to and come from a link layer outside this block. Payload dwords pass through a read-data port and a write-data port that connect to a memory mover.

Read data may arrive in any number of unsolicited data frames. Write data leaves one data frame per activation from the device. Each such frame is sized to the remaining length, capped at a per-frame maximum. At completion the block latches the device status and error bytes and raises a one-cycle done pulse. It also reports a protocol error, a payload overrun or a payload underrun. The payload checks compare against sector count times 128 dwords.

Top module: `sata_dma_fis_seq`

## Requirements
- R1: A command is taken on `cmd_valid` only while `busy` is low. `busy` rises on the clock edge that takes the command and stays high until the edge that raises `done`. A `cmd_valid` seen while busy has no effect.
- R2: After a command is taken, the block sends a five-dword frame with `tx_sof` on dword 0 and `tx_eof` on dword 4. The dwords are:
  - dword0 = {8'h00, opcode, 8'h80, 8'h27}
  - dword1 = {8'h40, lba[23:0]}
  - dword2 = {8'h00, lba[47:24]}
  - dword3 = {16'h0000, sector count zero-extended to 16 bits}
  - dword4 = 0
- R3: For a read, every inbound frame whose first dword has type 0x46 in bits 7:0 is a data frame. Its later dwords appear on `rd_data` with `rd_valid`, and the header dword is not passed on. Any number of data frames is accepted before the status frame.
- R4: For a write, no dword leaves `tx_*` after the command frame until the device sends a frame of type 0x39. Each such frame releases exactly one data frame: header dword 0x00000046 with `tx_sof`, then min(remaining dwords, MAX_FIS_DW) dwords from `wr_data`, with `tx_eof` on the last of them.
- R5: A frame of type 0x34 ends the command. Bits 23:16 of its first dword go to `dev_status` and bits 31:24 go to `dev_error`. `dev_err` equals status bit 0. `done` is high for one cycle, in the cycle after the frame's end-of-frame dword is taken.
- R6: At completion, `overrun` is set when more payload dwords were moved than sector count × 128. `underrun` is set when fewer were moved.
- R7: Any frame type other than those allowed in the current direction aborts the command with `done` and `proto_err`. A read allows 0x46 and 0x34. A write allows 0x39 and 0x34.
- R8: If no inbound dword arrives for TIMEOUT consecutive cycles while the block waits for a device frame, the command ends with `done` and `proto_err`.
- R9: A type 0x39 frame that arrives for a write with no payload left ends the command with `done` and `proto_err`, and no data frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = DMA write, 0 = DMA read |
| cmd_opcode | input | 8 | ATA command code |
| cmd_lba | input | 48 | Starting block address |
| cmd_sectors | input | SEC_W | Sector count |
| busy | output | 1 | Command in progress |
| tx_valid | output | 1 | Outbound dword valid |
| tx_sof | output | 1 | Outbound start of frame |
| tx_eof | output | 1 | Outbound end of frame |
| tx_data | output | 32 | Outbound dword |
| tx_ready | input | 1 | Link accepts outbound dword |
| rx_valid | input | 1 | Inbound dword valid |
| rx_sof | input | 1 | Inbound start of frame |
| rx_eof | input | 1 | Inbound end of frame |
| rx_data | input | 32 | Inbound dword |
| rd_valid | output | 1 | Read payload dword valid |
| rd_data | output | 32 | Read payload dword |
| wr_valid | input | 1 | Write payload dword available |
| wr_data | input | 32 | Write payload dword |
| wr_ready | output | 1 | Write payload dword taken |
| done | output | 1 | One-cycle completion pulse |
| dev_err | output | 1 | Device status error bit |
| dev_status | output | 8 | Latched device status byte |
| dev_error | output | 8 | Latched device error byte |
| proto_err | output | 1 | Protocol error or timeout |
| overrun | output | 1 | More payload than requested |
| underrun | output | 1 | Less payload than requested |

## Verification
Reads are tried with an exact fit of two frames and with three oversized frames, which separates overrun from underrun. A single short frame is also tried and must report underrun only. Writes are tried with a length that ends in a partial final chunk, which shows that the chunk size follows the remaining count and not the cap. A write is also cut short by the device, which must report underrun. Directed cases cover the following:
- a command strobe while busy;
- a data frame during a write;
- an activation after the write payload is used up;
- silence from the device.

These tell the abort paths apart from normal completion.

// File: rtl/sata_fis_pkg.sv
package sata_fis_pkg;
  localparam logic [7:0] FT_H2D_REG = 8'h27;
  localparam logic [7:0] FT_D2H_REG = 8'h34;
  localparam logic [7:0] FT_DMA_ACT = 8'h39;
  localparam logic [7:0] FT_DATA    = 8'h46;
  localparam int REG_FIS_DW = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WAIT, S_RDAT, S_SKIP, S_THDR, S_TDAT
  } seq_state_t;
endpackage

// File: rtl/sata_fis_len_acct.sv
module sata_fis_len_acct #(
  parameter int CNT_W  = 24,
  parameter int MAX_DW = 2048,
  localparam int CH_W  = $clog2(MAX_DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] remaining,
  output logic [CH_W-1:0]  chunk,
  output logic             over,
  output logic             under
);
  logic [CNT_W-1:0] moved;

  always_ff @(posedge clk) begin
    if (rst || clear) moved <= '0;
    else if (inc && (moved != {CNT_W{1'b1}})) moved <= moved + 1'b1;
  end

  always_comb begin
    remaining = (moved >= total) ? '0 : (total - moved);
    chunk     = (remaining > CNT_W'(MAX_DW)) ? CH_W'(MAX_DW) : remaining[CH_W-1:0];
    over      = moved > total;
    under     = moved < total;
  end

  // R6: the moved count only grows between clears
  assert_moved_mono_R6: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (moved >= $past(moved)));
endmodule

// File: rtl/sata_fis_timer.sv
module sata_fis_timer #(
  parameter int LIMIT = 100000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  output logic fire
);
  logic [TW-1:0] cnt;

  assign fire = run && !kick && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || kick) cnt <= '0;
    else if (!fire) cnt <= cnt + 1'b1;
  end

  // R8: the idle count stays inside its window
  assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT - 1));
endmodule

// File: rtl/sata_dma_fis_seq.sv
module sata_dma_fis_seq
  import sata_fis_pkg::*;
#(
  parameter int SEC_W      = 16,
  parameter int MAX_FIS_DW = 2048,
  parameter int TIMEOUT    = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [7:0]       cmd_opcode,
  input  logic [47:0]      cmd_lba,
  input  logic [SEC_W-1:0] cmd_sectors,
  output logic             busy,
  output logic             tx_valid,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic [31:0]      tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [31:0]      rx_data,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             done,
  output logic             dev_err,
  output logic [7:0]       dev_status,
  output logic [7:0]       dev_error,
  output logic             proto_err,
  output logic             overrun,
  output logic             underrun
);
  localparam int CNT_W = SEC_W + 8;
  localparam int CH_W  = $clog2(MAX_FIS_DW + 1);

  seq_state_t       st;
  logic [2:0]       idx;
  logic             dir_wr;
  logic [7:0]       opc;
  logic [47:0]      lba;
  logic [SEC_W-1:0] sec;
  logic [CH_W-1:0]  chunk_left;
  logic [31:0]      reg_dw;
  logic [CNT_W-1:0] total, remaining;
  logic [CH_W-1:0]  chunk;
  logic             acc_over, acc_under, tmo_fire, mv_inc, hdr, fin, fin_p;
  logic [7:0]       rx_type;

  assign total   = {1'b0, sec, 7'b0};
  assign rx_type = rx_data[7:0];
  assign hdr     = (st == S_WAIT) && rx_valid && rx_sof;
  assign dev_err = dev_status[0];

  sata_fis_len_acct #(.CNT_W(CNT_W), .MAX_DW(MAX_FIS_DW)) u_acct (
    .clk(clk), .rst(rst), .clear(st == S_IDLE), .inc(mv_inc), .total(total),
    .remaining(remaining), .chunk(chunk), .over(acc_over), .under(acc_under));

  sata_fis_timer #(.LIMIT(TIMEOUT)) u_tmo (
    .clk(clk), .rst(rst), .run(st == S_WAIT), .kick(rx_valid), .fire(tmo_fire));

  always_comb begin
    case (idx)
      3'd0:    reg_dw = {8'h00, opc, 8'h80, FT_H2D_REG};
      3'd1:    reg_dw = {8'h40, lba[23:0]};
      3'd2:    reg_dw = {8'h00, lba[47:24]};
      3'd3:    reg_dw = {16'h0000, 16'(sec)};
      default: reg_dw = 32'h0;
    endcase
  end

  always_comb begin
    tx_valid = 1'b0; tx_sof = 1'b0; tx_eof = 1'b0; tx_data = 32'h0;
    case (st)
      S_CMD:  begin tx_valid = 1'b1; tx_data = reg_dw;
                    tx_sof = (idx == 3'd0); tx_eof = (idx == 3'(REG_FIS_DW - 1)); end
      S_THDR: begin tx_valid = 1'b1; tx_data = {24'h0, FT_DATA}; tx_sof = 1'b1; end
      S_TDAT: begin tx_valid = wr_valid; tx_data = wr_data;
                    tx_eof = (chunk_left == CH_W'(1)); end
      default: ;
    endcase
  end

  assign wr_ready = (st == S_TDAT) && tx_ready;
  assign rd_valid = (st == S_RDAT) && rx_valid;
  assign rd_data  = rx_data;
  assign mv_inc   = rd_valid || (wr_valid && wr_ready);

  always_comb begin
    fin = 1'b0; fin_p = 1'b0;
    if (st == S_WAIT) begin
      if (tmo_fire) fin_p = 1'b1;
      else if (hdr) begin
        case (rx_type)
          FT_D2H_REG: fin   = rx_eof;
          FT_DATA:    fin_p = dir_wr;
          FT_DMA_ACT: fin_p = !dir_wr || (remaining == '0);
          default:    fin_p = 1'b1;
        endcase
      end
    end else if (st == S_SKIP) fin = rx_valid && rx_eof;
    fin = fin || fin_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; idx <= '0; busy <= 1'b0; done <= 1'b0; dir_wr <= 1'b0;
      opc <= '0; lba <= '0; sec <= '0; chunk_left <= '0;
      dev_status <= '0; dev_error <= '0; proto_err <= 1'b0;
      overrun <= 1'b0; underrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        st <= S_IDLE; busy <= 1'b0; done <= 1'b1; proto_err <= fin_p;
        overrun <= acc_over; underrun <= acc_under;
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          st <= S_CMD; busy <= 1'b1; idx <= '0; dir_wr <= cmd_write;
          opc <= cmd_opcode; lba <= cmd_lba; sec <= cmd_sectors;
          dev_status <= '0; dev_error <= '0; proto_err <= 1'b0;
          overrun <= 1'b0; underrun <= 1'b0;
        end
        S_CMD: if (tx_ready) begin
          idx <= idx + 1'b1;
          if (idx == 3'(REG_FIS_DW - 1)) st <= S_WAIT;
        end
        S_WAIT: if (hdr && !fin_p) begin
          case (rx_type)
            FT_D2H_REG: begin
              dev_status <= rx_data[23:16]; dev_error <= rx_data[31:24];
              if (!rx_eof) st <= S_SKIP;
            end
            FT_DATA:    if (!rx_eof) st <= S_RDAT;
            FT_DMA_ACT: begin chunk_left <= chunk; st <= S_THDR; end
            default: ;
          endcase
        end
        S_RDAT: if (rx_valid && rx_eof) st <= S_WAIT;
        S_THDR: if (tx_ready) st <= S_TDAT;
        S_TDAT: if (wr_valid && tx_ready) begin
          chunk_left <= chunk_left - 1'b1;
          if (chunk_left == CH_W'(1)) st <= S_WAIT;
        end
        default: ;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_rd_only_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !dir_wr);
  assert_wr_only_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> dir_wr);
  assert_tmo_aborts_R8: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |=> (done && proto_err));
  assert_len_excl_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !(overrun && underrun));
endmodule

// File: tb/sata_dma_fis_seq_bench.sv
module sata_dma_fis_seq_bench;
  localparam int SEC_W = 8;
  localparam int MAXD  = 48;
  localparam int TMO   = 60;

  typedef struct packed {
    logic wr; logic [7:0] sec; logic [7:0] nfis; logic [11:0] fdw;
    logic [7:0] st; logic [7:0] eb;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 8'd1, 8'd2, 12'd64,  8'h50, 8'h00},
    '{1'b0, 8'd2, 8'd3, 12'd100, 8'h51, 8'h04},
    '{1'b0, 8'd1, 8'd1, 12'd40,  8'h50, 8'h00},
    '{1'b1, 8'd1, 8'd3, 12'd0,   8'h50, 8'h00},
    '{1'b1, 8'd2, 8'd2, 12'd0,   8'h51, 8'h10}
  };

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_write = 0;
  logic [7:0] cmd_opcode = 0;
  logic [47:0] cmd_lba = 0;
  logic [SEC_W-1:0] cmd_sectors = 0;
  logic busy, tx_valid, tx_sof, tx_eof, rd_valid, wr_ready, done, dev_err;
  logic proto_err, overrun, underrun;
  logic [31:0] tx_data, rd_data, wr_data;
  logic [7:0] dev_status, dev_error;
  logic tx_ready = 1, rx_valid = 0, rx_sof = 0, rx_eof = 0, wr_valid = 1;
  logic [31:0] rx_data = 0;

  sata_dma_fis_seq #(.SEC_W(SEC_W), .MAX_FIS_DW(MAXD), .TIMEOUT(TMO)) u_sata_dma_fis_seq (
    .clk, .rst, .cmd_valid, .cmd_write, .cmd_opcode, .cmd_lba, .cmd_sectors, .busy,
    .tx_valid, .tx_sof, .tx_eof, .tx_data, .tx_ready, .rx_valid, .rx_sof, .rx_eof,
    .rx_data, .rd_valid, .rd_data, .wr_valid, .wr_data, .wr_ready, .done, .dev_err,
    .dev_status, .dev_error, .proto_err, .overrun, .underrun);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int tx_n = 0, rd_n = 0, wr_cnt = 0;
  logic [31:0] rd_sum = 0;
  logic [31:0] tx_d [0:2047];
  logic        tx_s [0:2047];
  logic        tx_e [0:2047];

  assign wr_data = 32'hA500_0000 + wr_cnt;

  always @(posedge clk) if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_d[tx_n] <= tx_data; tx_s[tx_n] <= tx_sof; tx_e[tx_n] <= tx_eof;
      tx_n <= tx_n + 1;
    end
    if (rd_valid) begin rd_n <= rd_n + 1; rd_sum <= rd_sum + rd_data; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic issue(input logic w, input logic [7:0] op, input logic [47:0] a, input logic [7:0] s);
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_opcode = op; cmd_lba = a; cmd_sectors = s;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_frame(input logic [31:0] hdr, input int n, input logic [31:0] base);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n);
      rx_data = (i == 0) ? hdr : base + 32'(i - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic wait_tx(input int target);
    for (int i = 0; i < 300 && tx_n < target; i++) @(negedge clk);
  endtask

  task automatic check_reg_fis(input int b, input logic [7:0] op, input logic [47:0] a, input logic [7:0] s);
    logic ok;
    ok = (tx_n >= b + 5) && tx_s[b] && tx_e[b+4] && !tx_e[b] &&
         tx_d[b]   == {8'h00, op, 8'h80, 8'h27} &&
         tx_d[b+1] == {8'h40, a[23:0]} &&
         tx_d[b+2] == {8'h00, a[47:24]} &&
         tx_d[b+3] == {24'h0, s} && tx_d[b+4] == 32'h0;
    chk(ok, "R2 command frame", tx_d[b], {8'h00, op, 8'h80, 8'h27});
  endtask

  initial begin
    int tb, rb, wb, moved, total, rem, c, bad;
    logic [31:0] rs, esum;
    logic [47:0] a;
    logic [7:0]  op;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !tx_valid && !proto_err, "R1 reset idle",
        {busy, done, tx_valid, proto_err}, 0);

    foreach (VECS[v]) begin
      tb = tx_n; rb = rd_n; rs = rd_sum; wb = wr_cnt;
      op = VECS[v].wr ? 8'h35 : 8'h25;
      a  = 48'h1234_5678_9A00 + 48'(v);
      total = VECS[v].sec * 128; moved = 0;
      issue(VECS[v].wr, op, a, VECS[v].sec);
      wait_tx(tb + 5);
      check_reg_fis(tb, op, a, VECS[v].sec);
      if (v == 0) begin
        issue(1'b1, 8'hAA, 48'h0, 8'd3);   // R1: strobe while busy
      end
      if (!VECS[v].wr) begin
        esum = 0;
        for (int f = 0; f < VECS[v].nfis; f++) begin
          send_frame(32'h46, VECS[v].fdw, 32'hC000_0000 + (f << 12));
          for (int i = 0; i < VECS[v].fdw; i++) esum += 32'hC000_0000 + (f << 12) + i;
          moved += VECS[v].fdw;
        end
        chk((rd_n - rb) == moved, "R3 read payload count", rd_n - rb, moved);
        chk((rd_sum - rs) == esum, "R3 read payload sum", rd_sum - rs, esum);
      end else begin
        rem = total;
        repeat (10) @(negedge clk);
        chk(tx_n == tb + 5, "R4 no data before activate", tx_n - tb, 5);
        for (int f = 0; f < VECS[v].nfis; f++) begin
          int pb;
          c = (rem > MAXD) ? MAXD : rem;
          pb = tx_n;
          send_frame(32'h39, 0, 0);
          wait_tx(pb + 1 + c);
          repeat (3) @(negedge clk);
          bad = 0;
          for (int i = 0; i < c; i++)
            if (tx_d[pb+1+i] != 32'hA500_0000 + 32'(wb + moved + i)) bad++;
          chk((tx_n == pb + 1 + c) && tx_s[pb] && tx_d[pb] == 32'h46 &&
              tx_e[pb+c] && !tx_e[pb+c-1] && bad == 0,
              "R4 one data frame per activate", tx_n - pb, 1 + c);
          moved += c; rem -= c;
        end
      end
      send_frame({VECS[v].eb, VECS[v].st, 8'h00, 8'h34}, 4, 0);
      chk(done && !proto_err, "R5 done after status frame", {done, proto_err}, 2'b10);
      chk(dev_status == VECS[v].st && dev_error == VECS[v].eb && dev_err == VECS[v].st[0],
          "R5 status latch", {dev_err, dev_status, dev_error}, {VECS[v].st[0], VECS[v].st, VECS[v].eb});
      chk(overrun == (moved > total) && underrun == (moved < total), "R6 length report",
          {overrun, underrun}, {moved > total, moved < total});
      @(negedge clk);
      chk(!done && !busy, "R5 single pulse", {done, busy}, 0);
      if (v == 0) begin
        repeat (5) @(negedge clk);
        chk(tx_n == tb + 5 && !busy, "R1 busy strobe ignored", tx_n - tb, 5);
      end
    end

    // R7: data frame during a write
    tb = tx_n;
    issue(1'b1, 8'h35, 48'h10, 8'd1);
    wait_tx(tb + 5);
    send_frame(32'h46, 0, 0);
    chk(done && proto_err, "R7 unexpected type aborts", {done, proto_err}, 2'b11);
    repeat (5) @(negedge clk);
    chk(tx_n == tb + 5 && !busy, "R7 nothing sent after abort", tx_n - tb, 5);

    // R9: activation with nothing left
    tb = tx_n;
    issue(1'b1, 8'h35, 48'h20, 8'd1);
    wait_tx(tb + 5);
    for (int f = 0; f < 3; f++) begin
      int pb;
      pb = tx_n;
      send_frame(32'h39, 0, 0);
      wait_tx(pb + 1 + ((f == 2) ? 32 : 48));
    end
    repeat (3) @(negedge clk);
    tb = tx_n;
    send_frame(32'h39, 0, 0);
    chk(done && proto_err && !overrun && !underrun, "R9 surplus activate aborts",
        {done, proto_err, overrun, underrun}, 4'b1100);
    repeat (5) @(negedge clk);
    chk(tx_n == tb, "R9 no data frame", tx_n - tb, 0);

    // R8: silent device
    tb = tx_n;
    issue(1'b0, 8'h25, 48'h30, 8'd1);
    wait_tx(tb + 5);
    repeat (40) @(negedge clk);
    chk(!done && busy, "R8 no early timeout", {done, busy}, 2'b01);
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    chk(done && proto_err && underrun, "R8 timeout aborts", {done, proto_err, underrun}, 3'b111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule